// File: doc/BRIEF.md
# Register-Driven Quad SPI Shifter

This block lets a host run serial-flash style transactions one word at a time. The host sends requests on a valid/ready request channel. A write to one of the transfer addresses starts a shift of one to four bytes. The address alone selects the line mode and the byte count; the data word only carries the bytes to send, taken from its top end. Three line modes are offered:

- single-line full duplex, with data out on lane 0 and data in on lane 1;
- four-lane read, with all lanes released;
- four-lane write, reachable at two address groups that behave the same.

A control address selects and releases one chip select. Longer transactions are built by issuing several word commands while the chip select stays low. Dummy cycles are read transfers whose result is thrown away. A read of the receive register returns the bits captured by the last single-line or four-lane read, right-aligned.

Back-pressure: `req_ready` is low for the whole of a running transfer. Every request, read or write, waits while it is low, and is accepted on the rising clock edge where `req_valid` and `req_ready` are both high. A read response appears on `rsp_valid` for one cycle, in the cycle right after acceptance. The response channel has no ready signal, so the host must always take it.

Top module: `qspi_reg_shifter`

## Requirements
- R1: After reset, `spi_cs_n` is all ones, `spi_clk` is low, `spi_io_oe` is 0, `spi_io_out` is 0, `req_ready` is 1, and the receive register (address 3) reads 0.
- R2: Control register writes (address 0):
  - with bit 2 set, all chip selects go high, whatever bit 1 holds;
  - with bit 2 clear and bit 1 set, only `spi_cs_n[k]` goes low, where k is the value in bits 5:4;
  - with both bits clear, the chip selects are unchanged.
  - The new value shows in the cycle after acceptance.
- R3: A write to address 0x10+(n-1), n = 1..4, runs a single-line transfer of 8n bits. `spi_io_oe` is 4'b0001. `spi_io_out[0]` carries `req_wdata` starting at bit 31, one bit at a time, and each bit is held for one low and one high phase of `spi_clk`.
- R4: In single-line mode, `spi_io_in[1]` is sampled at every rising `spi_clk`. After the transfer, address 3 holds the 8n captured bits in its low bits, first bit most significant, with zeros above.
- R5: A write to address 0x14+(n-1) runs a four-lane read of 2n nibbles with `spi_io_oe` = 0. `spi_io_in[3:0]` is sampled at each rising `spi_clk`, high nibble first, and the result is right-aligned in address 3 as in R4.
- R6: A write to address 0x18+(n-1) or 0x1C+(n-1) runs a four-lane write. `spi_io_oe` is 4'hF, and `spi_io_out` carries 2n nibbles starting with `req_wdata[31:28]`. The receive register keeps its previous value.
- R7: After a transfer command is accepted, `req_ready` stays low for exactly 16n cycles in single-line mode and 4n cycles in four-lane modes. Requests presented in that time wait and are not lost.
- R8: A read request receives `rsp_valid` high for exactly the next cycle. `rsp_rdata` is the receive register for address 3 and 0 for every other address.
- R9: `spi_clk` is low when idle. During a transfer it is high for single cycles, separated by single low cycles.
- R10: Transfer commands never change the chip selects, so a chip select stays low across consecutive commands.
- R11: Writes to addresses 1 to 15 other than 0 (including address 3) change neither the chip selects nor the receive register, and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address; bit 4 set selects a transfer command |
| req_wdata | input | WORD_W | Write data; bytes to send from the top |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | WORD_W | Read data |
| spi_clk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
The reference model in the bench predicts each pin in every cycle, and a serial device model there returns a known word from its own shift counter.

Transfers are tried with several patterns, and each pattern tells apart a different fault:
- Full-length single-line words show bit order and lane choice.
- A one-byte single-line transfer and a three-byte four-lane read show whether short results are right-aligned.
- Four-lane writes that follow a read show whether the receive register is left untouched.
- A command issued while another is running shows that requests wait rather than being dropped.
- Control words with both bits set, with neither bit set, and with each select value tell the priority of release apart from a plain update.

// File: rtl/qspi_rs_pkg.sv
package qspi_rs_pkg;
  // line mode, taken straight from address bits 3:2 of a transfer command
  typedef enum logic [1:0] {
    LINE_SINGLE = 2'b00,
    LINE_QREAD  = 2'b01,
    LINE_QWRITE = 2'b10,
    LINE_QCMD   = 2'b11
  } line_mode_e;

  localparam int                ADDR_W       = 5;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_RXWORD  = 5'd3;
  localparam int                CTRL_REL_BIT = 2;
  localparam int                CTRL_SET_BIT = 1;
  localparam int                CTRL_SEL_LSB = 4;
  localparam int                QUAD_LANES   = 4;
endpackage

// File: rtl/qspi_rs_decode.sv
module qspi_rs_decode
  import qspi_rs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output logic              do_xfer,
  output logic              do_ctrl,
  output logic              rd_rxword,
  output line_mode_e        mode,
  output logic [2:0]        nbytes
);
  localparam int BYTES = WORD_W / 8;

  always_comb begin
    do_xfer   = is_write && addr[ADDR_W-1];
    do_ctrl   = is_write && (addr == ADDR_CTRL);
    rd_rxword = !is_write && (addr == ADDR_RXWORD);
    mode      = line_mode_e'(addr[3:2]);
    nbytes    = 3'(addr[1:0]) + 3'd1;
    if (int'(nbytes) > BYTES) nbytes = 3'(BYTES);
  end
endmodule

// File: rtl/qspi_rs_csel.sv
module qspi_rs_csel
  import qspi_rs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int FLD_W = CTRL_SEL_LSB + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] ctrl_word,
  output logic [NUM_CS-1:0] cs_n
);
  logic             rel;
  logic             set;
  logic [SEL_W-1:0] sel;
  logic [3:0]       unused_low;

  assign rel        = ctrl_word[CTRL_REL_BIT];
  assign set        = ctrl_word[CTRL_SET_BIT];
  assign sel        = ctrl_word[FLD_W-1:CTRL_SEL_LSB];
  assign unused_low = {ctrl_word[3], ctrl_word[0], 2'b00};

  // one flop per select line; release outranks assert
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cs_n[i] <= 1'b1;
      else if (wr_en) begin
        if (rel)
          cs_n[i] <= 1'b1;
        else if (set)
          cs_n[i] <= !(int'(sel) == i);
      end
    end
  end
endmodule

// File: rtl/qspi_rs_shift.sv
module qspi_rs_shift
  import qspi_rs_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int STEP_W = $clog2(WORD_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  line_mode_e            mode,
  input  logic [2:0]            nbytes,
  input  logic [WORD_W-1:0]     tx_word,
  output logic                  busy,
  output logic                  sclk,
  output logic [QUAD_LANES-1:0] io_out,
  output logic [QUAD_LANES-1:0] io_oe,
  input  logic [QUAD_LANES-1:0] io_in,
  output logic [WORD_W-1:0]     rx_word
);
  logic              busy_q;
  logic              phase_q;
  logic [STEP_W-1:0] steps_q;
  logic [STEP_W-1:0] steps_init;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] tx_next;
  logic [WORD_W-1:0] rx_q;
  logic [WORD_W-1:0] rx_next;
  line_mode_e        mode_q;
  logic              capture;
  logic              single;

  assign single  = (mode_q == LINE_SINGLE);
  assign capture = (mode_q == LINE_SINGLE) || (mode_q == LINE_QREAD);

  always_comb begin
    if (mode == LINE_SINGLE) steps_init = STEP_W'({nbytes, 3'b000});
    else                     steps_init = STEP_W'({nbytes, 1'b0});
  end

  always_comb begin
    if (single) begin
      tx_next = {tx_q[WORD_W-2:0], 1'b0};
      rx_next = {rx_q[WORD_W-2:0], io_in[1]};
    end else begin
      tx_next = {tx_q[WORD_W-QUAD_LANES-1:0], {QUAD_LANES{1'b0}}};
      rx_next = {rx_q[WORD_W-QUAD_LANES-1:0], io_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      steps_q <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      mode_q  <= LINE_SINGLE;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      steps_q <= steps_init;
      tx_q    <= tx_word;
      mode_q  <= mode;
      if (mode == LINE_SINGLE || mode == LINE_QREAD) rx_q <= '0;
    end else if (busy_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;                 // rising serial edge: sample
        if (capture) rx_q <= rx_next;
      end else begin
        phase_q <= 1'b0;                 // falling serial edge: advance
        tx_q    <= tx_next;
        steps_q <= steps_q - 1'b1;
        if (steps_q == STEP_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  // lane drivers
  for (genvar l = 0; l < QUAD_LANES; l++) begin : g_lane
    always_comb begin
      io_out[l] = 1'b0;
      io_oe[l]  = 1'b0;
      if (busy_q) begin
        if (single) begin
          if (l == 0) begin
            io_out[l] = tx_q[WORD_W-1];
            io_oe[l]  = 1'b1;
          end
        end else if (mode_q != LINE_QREAD) begin
          io_out[l] = tx_q[WORD_W-QUAD_LANES+l];
          io_oe[l]  = 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = phase_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/qspi_reg_shifter.sv
module qspi_reg_shifter
  import qspi_rs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              spi_clk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int FLD_W = CTRL_SEL_LSB + SEL_W;

  logic              accept;
  logic              busy;
  logic              do_xfer;
  logic              do_ctrl;
  logic              rd_rxword;
  line_mode_e        mode;
  logic [2:0]        nbytes;
  logic [WORD_W-1:0] rx_word;
  logic              rsp_v_q;
  logic [WORD_W-1:0] rsp_d_q;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  qspi_rs_decode #(.WORD_W(WORD_W)) u_dec (
    .is_write (req_write),
    .addr     (req_addr),
    .do_xfer  (do_xfer),
    .do_ctrl  (do_ctrl),
    .rd_rxword(rd_rxword),
    .mode     (mode),
    .nbytes   (nbytes)
  );

  qspi_rs_csel #(.NUM_CS(NUM_CS)) u_csel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept && do_ctrl),
    .ctrl_word(req_wdata[FLD_W-1:0]),
    .cs_n     (spi_cs_n)
  );

  qspi_rs_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept && do_xfer),
    .mode   (mode),
    .nbytes (nbytes),
    .tx_word(req_wdata),
    .busy   (busy),
    .sclk   (spi_clk),
    .io_out (spi_io_out),
    .io_oe  (spi_io_oe),
    .io_in  (spi_io_in),
    .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= accept && !req_write;
      if (accept && !req_write) rsp_d_q <= rd_rxword ? rx_word : '0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;
endmodule

// File: rtl/qspi_reg_shifter_chk.sv
module qspi_reg_shifter_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              spi_clk,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic [3:0]        spi_io_oe
);
  // R9: serial clock high phases last a single cycle
  p_clk_single_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_clk |=> !spi_clk);

  // R7: no request can be taken while the serial clock runs
  p_stall_while_clocking_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_clk |-> !req_ready);

  // R2: at most one chip select is active
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R10: chip selects hold still during a transfer
  p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $stable(spi_cs_n));

  // R3 / R5 / R6: enables are idle, lane 0 only, or all four lanes
  p_oe_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe == 4'h0) || (spi_io_oe == 4'h1) || (spi_io_oe == 4'hF));

  // R3: enables do not change inside a transfer
  p_oe_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(spi_io_oe));

  // R8: a response follows only an accepted read
  p_rsp_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R8: an accepted read always gets its response
  p_read_gets_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind qspi_reg_shifter qspi_reg_shifter_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .spi_clk  (spi_clk),
  .spi_cs_n (spi_cs_n),
  .spi_io_oe(spi_io_oe)
);

// File: tb/qspi_reg_shifter_tb.sv
module qspi_reg_shifter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        spi_clk;
  logic [3:0]  spi_cs_n;
  logic [3:0]  spi_io_out;
  logic [3:0]  spi_io_oe;
  logic [3:0]  spi_io_in;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_reg_shifter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .spi_clk(spi_clk), .spi_cs_n(spi_cs_n),
    .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- serial device model ----------------
  int          fall_cnt = 0;
  int          base_cnt = 0;
  logic [31:0] slv_base = '0;
  bit          slv_quad = 0;
  logic [31:0] slv_cur;

  always @(negedge spi_clk) fall_cnt++;

  always_comb begin
    int sh;
    sh = (fall_cnt - base_cnt) * (slv_quad ? 4 : 1);
    slv_cur = (sh >= 32 || sh < 0) ? 32'h0 : (slv_base << sh);
  end
  assign spi_io_in = slv_quad ? slv_cur[31:28] : {2'b00, slv_cur[31], 1'b0};

  // ---------------- behavioural reference model ----------------
  bit          m_busy = 0;
  int          m_half = 0;
  int          m_mode = 0;
  logic [31:0] m_tx = '0;
  logic [31:0] m_rx = '0;
  logic [3:0]  m_cs = 4'hF;
  bit          m_rsp_v = 0;
  logic [31:0] m_rsp_d = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_half = 0; m_tx = '0; m_rx = '0; m_cs = 4'hF;
      m_rsp_v = 0; m_rsp_d = '0; m_mode = 0;
    end else begin
      m_rsp_v = 0;
      if (m_busy) begin
        if (m_half % 2 == 0) begin
          if (m_mode == 0)      m_rx = {m_rx[30:0], spi_io_in[1]};
          else if (m_mode == 1) m_rx = {m_rx[27:0], spi_io_in};
        end else begin
          m_tx = (m_mode == 0) ? (m_tx << 1) : (m_tx << 4);
        end
        m_half--;
        if (m_half == 0) m_busy = 0;
      end else if (req_valid) begin
        if (req_write) begin
          if (req_addr >= 5'h10) begin
            int n;
            m_mode = int'(req_addr[3:2]);
            n = int'(req_addr[1:0]) + 1;
            m_busy = 1;
            m_half = 2 * ((m_mode == 0) ? 8 * n : 2 * n);
            m_tx = req_wdata;
            if (m_mode <= 1) m_rx = '0;
          end else if (req_addr == 5'd0) begin
            if (req_wdata[2])      m_cs = 4'hF;
            else if (req_wdata[1]) m_cs = ~(4'b0001 << req_wdata[5:4]);
          end
        end else begin
          m_rsp_v = 1;
          m_rsp_d = (req_addr == 5'd3) ? m_rx : 32'h0;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [3:0] e_out, e_oe;
      e_out = 4'h0; e_oe = 4'h0;
      if (m_busy) begin
        if (m_mode == 0)      begin e_out = {3'b000, m_tx[31]}; e_oe = 4'h1; end
        else if (m_mode >= 2) begin e_out = m_tx[31:28];        e_oe = 4'hF; end
      end
      chk(spi_clk == (m_busy && (m_half % 2 == 1)), "R9 spi_clk", 32'(spi_clk), 32'(m_busy && (m_half % 2 == 1)));
      chk(req_ready == !m_busy, "R7 req_ready", 32'(req_ready), 32'(!m_busy));
      chk(spi_cs_n == m_cs, "R2 spi_cs_n", 32'(spi_cs_n), 32'(m_cs));
      chk(spi_io_oe == e_oe, (m_mode == 0) ? "R3 io_oe" : "R5 io_oe", 32'(spi_io_oe), 32'(e_oe));
      chk(spi_io_out == e_out, (m_mode == 0) ? "R3 io_out" : "R6 io_out", 32'(spi_io_out), 32'(e_out));
      chk(rsp_valid == m_rsp_v, "R8 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
      if (m_rsp_v) chk(rsp_rdata == m_rsp_d, "R8 rsp_rdata", rsp_rdata, m_rsp_d);
    end
  end

  // ---------------- bus tasks (start at a negedge) ----------------
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_valid ? rsp_rdata : 32'hXXXX_XXXX;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (!req_ready) begin cyc++; @(negedge clk); end
  endtask

  task automatic load_slave(input logic [31:0] w, input bit q);
    slv_base = w; slv_quad = q; base_cnt = fall_cnt;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 4'hF, "R1 cs_n", 32'(spi_cs_n), 32'hF);
    chk(spi_clk == 0 && spi_io_oe == 0 && spi_io_out == 0, "R1 pins", {spi_clk, spi_io_oe, spi_io_out}, 0);
    chk(req_ready == 1, "R1 ready", 32'(req_ready), 1);
    bus_read(5'd3, rd);
    chk(rd == 0, "R1 rx reg", rd, 0);

    // R2 select chip 2
    bus_write(5'd0, 32'h22);
    chk(spi_cs_n == 4'b1011, "R2 select 2", 32'(spi_cs_n), 32'hB);

    // R3/R4 single 4 bytes
    load_slave(32'hA5C3_0F96, 0);
    bus_write(5'h13, 32'h1234_5678);
    wait_idle(cyc);
    chk(cyc == 64, "R7 single x4 duration", cyc, 64);
    bus_read(5'd3, rd);
    chk(rd == 32'hA5C3_0F96, "R4 single x4 rx", rd, 32'hA5C3_0F96);

    // R4 single 1 byte right aligned
    load_slave(32'h3C00_0000, 0);
    bus_write(5'h10, 32'h9A00_0000);
    wait_idle(cyc);
    chk(cyc == 16, "R7 single x1 duration", cyc, 16);
    bus_read(5'd3, rd);
    chk(rd == 32'h0000_003C, "R4 single x1 right aligned", rd, 32'h3C);

    // R5 quad read 3 bytes
    load_slave(32'hDEAD_BE00, 1);
    bus_write(5'h16, 32'hFFFF_FFFF);
    wait_idle(cyc);
    chk(cyc == 12, "R7 quad x3 duration", cyc, 12);
    bus_read(5'd3, rd);
    chk(rd == 32'h00DE_ADBE, "R5 quad x3 rx", rd, 32'h00DEADBE);

    // R6 quad write leaves rx alone; R10 cs held
    bus_write(5'h19, 32'hC0DE_0000);
    wait_idle(cyc);
    chk(cyc == 8, "R7 quad write x2 duration", cyc, 8);
    bus_write(5'h1C, 32'h6B00_0000);
    chk(spi_cs_n == 4'b1011, "R10 cs held through commands", 32'(spi_cs_n), 32'hB);
    wait_idle(cyc);
    bus_read(5'd3, rd);
    chk(rd == 32'h00DE_ADBE, "R6 rx unchanged by quad write", rd, 32'h00DEADBE);

    // R7 back-to-back: second command waits, both complete
    load_slave(32'h8100_0000, 0);
    bus_write(5'h10, 32'h5500_0000);
    bus_write(5'h11, 32'hAA55_0000);
    chk(req_ready == 0, "R7 second command accepted after first", 32'(req_ready), 0);
    wait_idle(cyc);
    chk(cyc == 32, "R7 queued command duration", cyc, 32);

    // R11 undefined writes ignored
    bus_read(5'd3, rd);
    bus_write(5'd5, 32'hFFFF_FFFF);
    chk(req_ready == 1 && spi_cs_n == 4'b1011, "R11 addr 5 no effect", {req_ready, spi_cs_n}, 32'h1B);
    bus_write(5'd3, 32'h0000_0000);
    begin
      logic [31:0] rd2;
      bus_read(5'd3, rd2);
      chk(rd2 == rd, "R11 rx unchanged by write to 3", rd2, rd);
    end

    // R2 priority and hold
    bus_write(5'd0, 32'h16);
    chk(spi_cs_n == 4'hF, "R2 release wins", 32'(spi_cs_n), 32'hF);
    bus_write(5'd0, 32'h32);
    chk(spi_cs_n == 4'b0111, "R2 select 3", 32'(spi_cs_n), 32'h7);
    bus_write(5'd0, 32'h10);
    chk(spi_cs_n == 4'b0111, "R2 no bits holds", 32'(spi_cs_n), 32'h7);
    bus_write(5'd0, 32'h04);
    chk(spi_cs_n == 4'hF, "R2 release", 32'(spi_cs_n), 32'hF);

    // R8 other addresses read zero
    bus_read(5'd0, rd);
    chk(rd == 0, "R8 read addr 0", rd, 0);
    bus_read(5'h12, rd);
    chk(rd == 0, "R8 read addr 0x12", rd, 0);

    repeat (4) @(negedge clk);
    cmp_en = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule